// File: doc/BRIEF.md
# Security-Banked Priority Register Array

This block holds one 8-bit priority value for every shared interrupt of an interrupt distributor. Software reaches the array over a simple request/response register bus. Each request is either a single byte or an aligned 32-bit word, and each carries a secure/non-secure attribute. The byte offset of a request is the interrupt number, so a word covers four consecutive interrupts.

While security is enabled (`sec_disable` low), a non-secure request sees only interrupts whose group bit is 1. Hidden entries read as zero and cannot be written. Visible entries are presented at reduced precision: a read returns the stored value shifted up by one bit, and a write is forced into the upper half of the priority range. Secure requests, and every request made while `sec_disable` is high, see the stored bytes unchanged.

Interrupt numbers below 32, or at or above the implemented count, are not backed by storage. The block does not compare, mask or pre-empt priorities.

A three-state machine tracks the response owed for the previous cycle:
- `ST_IDLE`: no response is due.
- `ST_READ_RSP`: read data is being presented.
- `ST_WRITE_RSP`: a write is being acknowledged.

Every clock edge moves the machine according to the request present at that edge:
- No request leads to `ST_IDLE`.
- A read request leads to `ST_READ_RSP`.
- A write request leads to `ST_WRITE_RSP`.

These transitions apply from every state, so back-to-back requests are accepted.

Top module: `prio_bank_regs`

## Requirements
- R1: After reset every priority byte reads as 0x00 and `rsp_valid` and `upd_strobe` are low.
- R2: A byte request addresses the priority of the interrupt whose number equals `req_addr`. A byte write takes its data from `req_wdata[7:0]`. A byte read returns its data in `rsp_rdata[7:0]`, with `rsp_rdata[31:8]` zero.
- R3: A word read returns the four priorities starting at `req_addr` with bits [1:0] cleared. The lowest-numbered interrupt is in `rsp_rdata[7:0]` and the next ones are in ascending byte lanes. A word write places `req_wdata` byte lane k into interrupt base+k.
- R4: A secure request (`req_secure`=1), or any request while `sec_disable`=1, reads and writes the raw stored byte.
- R5: With `sec_disable`=0, a non-secure request to an interrupt whose `irq_group` bit is 0 reads 0x00, and a write to it leaves the stored byte unchanged.
- R6: A non-secure read of a visible interrupt with `sec_disable`=0 returns the stored byte shifted left by one, keeping only 8 bits.
- R7: A non-secure write of value v to a visible interrupt with `sec_disable`=0 stores 0x80 | (v >> 1).
- R8: An interrupt number below 32, or at or above `NUM_IRQ`, reads as 0x00. A byte write to such a number is ignored. In a word read, each lane is judged on its own.
- R9: A word write is dropped as a whole if its base is below 32 or if base+3 is at or above `NUM_IRQ`.
- R10: `upd_strobe` is high for exactly the one cycle after a write that stored at least one byte. It is low after reads, idle cycles and fully ignored writes.
- R11: `rsp_valid` is high in the cycle after each request and low in the cycle after an idle cycle. `rsp_rdata` of a read is valid in that same cycle, and requests may be issued on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word access, 0 = byte access |
| req_secure | input | 1 | Security attribute of the request, 1 = secure |
| req_addr | input | ADDR_W | Byte offset, equal to the interrupt number |
| req_wdata | input | 32 | Write data |
| sec_disable | input | 1 | 1 = banking off, every request sees raw values |
| irq_group | input | NUM_IRQ | Group bit per interrupt, 1 = visible to non-secure requests |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data of the previous read |
| upd_strobe | output | 1 | One-cycle pulse after a write that stored data |

## Verification
A request and a change on `sec_disable` or an `irq_group` bit can arrive in the same cycle. In that case the view the request gets must follow the control values present at that clock edge, not those of the cycle before. The bench provokes this by changing the control inputs on the same edge as non-secure writes and reads, both in directed cases and in a random run. Its reference model applies the new control value before computing the expected stored byte, read data and strobe, and it judges the outputs every cycle. Back-to-back write-then-read of the same interrupt is exercised as well, to confirm that a read sees the byte written one cycle earlier.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int FIRST_SHARED = 32;
    localparam int LANES        = 4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_RSP  = 2'd1,
        ST_WRITE_RSP = 2'd2
    } rsp_state_e;

    // Reduced-precision view seen by non-secure readers
    function automatic logic [7:0] ns_read_view(input logic [7:0] stored);
        return {stored[6:0], 1'b0};
    endfunction

    // Non-secure writes land in the upper half of the range
    function automatic logic [7:0] ns_write_view(input logic [7:0] wbyte);
        return {1'b1, wbyte[7:1]};
    endfunction

endpackage

// File: rtl/prio_lane.sv
module prio_lane
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IW      = 11
) (
    input  logic [IW-1:0]      irq_idx,
    input  logic               secure,
    input  logic               sec_dis,
    input  logic [NUM_IRQ-1:0] irq_group,
    input  logic [7:0]         stored,
    input  logic [7:0]         wbyte,
    output logic               in_range,
    output logic               permit,
    output logic [7:0]         rd_byte,
    output logic [7:0]         wr_byte
);

    localparam int GW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [IW-1:0] LO_IDX = IW'(FIRST_SHARED);
    localparam logic [IW-1:0] HI_IDX = IW'(NUM_IRQ);

    logic raw_view;
    logic grp_bit;

    always_comb begin
        in_range = (irq_idx >= LO_IDX) && (irq_idx < HI_IDX);
        grp_bit  = in_range ? irq_group[irq_idx[GW-1:0]] : 1'b0;
        raw_view = secure || sec_dis;
        permit   = in_range && (raw_view || grp_bit);
    end

    always_comb begin
        if (!permit) begin
            rd_byte = 8'h00;
        end else if (raw_view) begin
            rd_byte = stored;
        end else begin
            rd_byte = ns_read_view(stored);
        end
        wr_byte = raw_view ? wbyte : ns_write_view(wbyte);
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int SI_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           wr_en,
    input  logic [LANES-1:0][SI_W-1:0] idx,
    input  logic [LANES-1:0][7:0]      wr_byte,
    output logic [LANES-1:0][7:0]      rd_byte
);

    localparam logic [SI_W-1:0] DEPTH_IDX = SI_W'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                mem[e] <= 8'h00;
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en[k] && (idx[k] < DEPTH_IDX)) begin
                    mem[idx[k]] <= wr_byte[k];
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        assign rd_byte[k] = (idx[k] < DEPTH_IDX) ? mem[idx[k]] : 8'h00;
    end

endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
    import prio_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_word,
    input  logic               req_secure,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               sec_disable,
    input  logic [NUM_IRQ-1:0] irq_group,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic               upd_strobe
);

    localparam int IW    = ADDR_W + 1;
    localparam int DEPTH = NUM_IRQ - FIRST_SHARED;
    localparam int SI_W  = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] SHARED_BASE = IW'(FIRST_SHARED);

    rsp_state_e state_q, state_d;

    logic [IW-1:0]               base_idx;
    logic [LANES-1:0][IW-1:0]    lane_idx;
    logic [LANES-1:0][SI_W-1:0]  lane_si;
    logic [LANES-1:0]            lane_act;
    logic [LANES-1:0]            lane_rng;
    logic [LANES-1:0]            lane_perm;
    logic [LANES-1:0]            lane_we;
    logic [LANES-1:0][7:0]       lane_stored;
    logic [LANES-1:0][7:0]       lane_rd;
    logic [LANES-1:0][7:0]       lane_wr;
    logic                        whole_ok;
    logic [31:0]                 rd_word;
    logic [31:0]                 rdata_q;
    logic                        upd_q;

    // Address decode: word requests ignore the two low address bits
    always_comb begin
        if (req_word) begin
            base_idx = {1'b0, req_addr[ADDR_W-1:2], 2'b00};
        end else begin
            base_idx = {1'b0, req_addr};
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IW-1:0] rel_idx;

        assign lane_idx[k] = base_idx + IW'(k);
        assign rel_idx     = lane_idx[k] - SHARED_BASE;
        assign lane_si[k]  = rel_idx[SI_W-1:0];
        assign lane_act[k] = (k == 0) ? 1'b1 : req_word;

        prio_lane #(
            .NUM_IRQ (NUM_IRQ),
            .IW      (IW)
        ) u_lane (
            .irq_idx   (lane_idx[k]),
            .secure    (req_secure),
            .sec_dis   (sec_disable),
            .irq_group (irq_group),
            .stored    (lane_stored[k]),
            .wbyte     (req_wdata[8*k +: 8]),
            .in_range  (lane_rng[k]),
            .permit    (lane_perm[k]),
            .rd_byte   (lane_rd[k]),
            .wr_byte   (lane_wr[k])
        );

        assign rd_word[8*k +: 8] = lane_act[k] ? lane_rd[k] : 8'h00;
        assign lane_we[k] = req_valid && req_write && lane_act[k] && lane_perm[k]
                            && (req_word ? whole_ok : lane_rng[k]);
    end

    // A word write needs both its first and its last interrupt in range
    assign whole_ok = lane_rng[0] && lane_rng[LANES-1];

    prio_store #(
        .DEPTH (DEPTH),
        .SI_W  (SI_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lane_we),
        .idx     (lane_si),
        .wr_byte (lane_wr),
        .rd_byte (lane_stored)
    );

    // Response state machine: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_READ_RSP, ST_WRITE_RSP: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (req_write) begin
                    state_d = ST_WRITE_RSP;
                end else begin
                    state_d = ST_READ_RSP;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers captured alongside the state change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= |lane_we;
            if (req_valid && !req_write) begin
                rdata_q <= rd_word;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid  = 1'b0;
        upd_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
            end
            ST_READ_RSP: begin
                rsp_valid = 1'b1;
            end
            ST_WRITE_RSP: begin
                rsp_valid  = 1'b1;
                upd_strobe = upd_q;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/prio_bank_sva.sv
module prio_bank_sva #(
    parameter int NUM_IRQ = 96,
    parameter int ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_word,
    input logic               req_secure,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               sec_disable,
    input logic [NUM_IRQ-1:0] irq_group,
    input logic               rsp_valid,
    input logic [31:0]        rsp_rdata,
    input logic               upd_strobe
);

    localparam int GW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic byte_rd;
    logic grp_at;
    logic ns_banked;

    always_comb begin
        byte_rd   = req_valid && !req_write && !req_word;
        grp_at    = (req_addr < ADDR_W'(NUM_IRQ)) ? irq_group[req_addr[GW-1:0]] : 1'b0;
        ns_banked = !req_secure && !sec_disable;
    end

    assert_rsp_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_after_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_upd_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> !upd_strobe);

    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rd |=> (rsp_rdata[31:8] == 24'h0));

    assert_hidden_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_rd && ns_banked && !grp_at) |=> (rsp_rdata == 32'h0));

    assert_ns_view_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_rd && ns_banked) |=> (rsp_rdata[0] == 1'b0));

    assert_low_ids_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_rd && (req_addr < ADDR_W'(32))) |=> (rsp_rdata == 32'h0));

endmodule

bind prio_bank_regs prio_bank_sva #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
) u_prio_bank_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_word    (req_word),
    .req_secure  (req_secure),
    .req_addr    (req_addr),
    .sec_disable (sec_disable),
    .irq_group   (irq_group),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .upd_strobe  (upd_strobe)
);

// File: tb/prio_bank_regs_bench.sv
module prio_bank_regs_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ    = 96;
    localparam int ADDR_W     = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic               req_word = 1'b0;
    logic               req_secure = 1'b0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [31:0]        req_wdata = '0;
    logic               sec_disable = 1'b0;
    logic [NUM_IRQ-1:0] irq_group = '0;
    logic               rsp_valid;
    logic [31:0]        rsp_rdata;
    logic               upd_strobe;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_bank_regs #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W)
    ) u_prio_bank_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_word    (req_word),
        .req_secure  (req_secure),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .sec_disable (sec_disable),
        .irq_group   (irq_group),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .upd_strobe  (upd_strobe)
    );

    int          checks = 0;
    int          errors = 0;
    bit          mon_on = 0;
    bit          done = 0;
    int          model [NUM_IRQ];
    bit          e_valid = 0;
    bit          e_read = 0;
    bit          e_upd = 0;
    logic [31:0] e_data = '0;
    string       e_tag = "R1";

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", e_tag, what, act, exp, $time);
        end
    endtask

    // Reference view of one priority slot
    function automatic int ref_read(input int i, input bit sec);
        if (i < 32 || i >= NUM_IRQ) return 0;
        if (!sec && !sec_disable) begin
            if (!irq_group[i]) return 0;
            return (model[i] * 2) % 256;
        end
        return model[i];
    endfunction

    function automatic bit ref_write(input int i, input bit sec, input int v);
        int s;
        if (i < 32 || i >= NUM_IRQ) return 0;
        s = v;
        if (!sec && !sec_disable) begin
            if (!irq_group[i]) return 0;
            s = 128 + v / 2;
        end
        model[i] = s;
        return 1;
    endfunction

    task automatic op(input bit wr, input bit word, input bit sec, input int addr,
                      input logic [31:0] wd, input string tag,
                      input bit chg = 0, input bit nd = 0);
        int b;
        @(negedge clk);
        if (chg) sec_disable = nd;
        req_valid  = 1'b1;
        req_write  = wr;
        req_word   = word;
        req_secure = sec;
        req_addr   = ADDR_W'(addr);
        req_wdata  = wd;
        e_valid = 1; e_read = !wr; e_tag = tag; e_upd = 0; e_data = '0;
        if (word) begin
            b = addr - (addr % 4);
            if (!wr) begin
                for (int k = 0; k < 4; k++) e_data[8*k +: 8] = 8'(ref_read(b + k, sec));
            end else if (b >= 32 && b + 3 < NUM_IRQ) begin
                for (int k = 0; k < 4; k++) begin
                    if (ref_write(b + k, sec, int'(wd[8*k +: 8]))) e_upd = 1;
                end
            end
        end else begin
            if (!wr) e_data = 32'(ref_read(addr, sec));
            else     e_upd  = ref_write(addr, sec, int'(wd[7:0]));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
            e_valid = 0; e_upd = 0; e_tag = "R11";
        end
    endtask

    task automatic set_grp(input int i, input bit v);
        @(negedge clk);
        req_valid = 1'b0;
        e_valid = 0; e_upd = 0; e_tag = "R11";
        irq_group[i] = v;
    endtask

    // Compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (mon_on) begin
            chk(32'(rsp_valid), 32'(e_valid), "rsp_valid");
            chk(32'(upd_strobe), 32'(e_upd), "upd_strobe");
            if (e_valid && e_read) chk(rsp_rdata, e_data, "rsp_rdata");
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        e_tag = "R1";
        chk(32'(rsp_valid), 0, "rsp_valid in reset");
        chk(32'(upd_strobe), 0, "upd_strobe in reset");
        rst_n = 1'b1;
        mon_on = 1;

        // R1: reset contents
        op(0, 1, 1, 32, 0, "R1 R3");
        op(0, 1, 1, 92, 0, "R1 R3");
        // R2 R4: raw byte write then read, back to back (R11)
        op(1, 0, 1, 40, 32'hFFFF_FFA5, "R2 R4 R10");
        op(0, 0, 1, 40, 0, "R2 R4 R11");
        // R3: word packing and address low bits ignored
        op(1, 1, 1, 44, 32'h4433_2211, "R3 R10");
        op(0, 1, 1, 44, 0, "R3");
        op(0, 1, 1, 46, 0, "R3");
        op(0, 0, 1, 45, 0, "R2 R3");
        idle(2);

        // R5 R6 R7: banked view
        for (int i = 48; i < 52; i++) set_grp(i, 1);
        op(1, 0, 0, 48, 32'h0000_0040, "R7 R10");
        op(0, 0, 1, 48, 0, "R7");
        op(0, 0, 0, 48, 0, "R6");
        op(1, 0, 0, 49, 32'h0000_00FF, "R7");
        op(0, 0, 0, 49, 0, "R6");
        op(1, 0, 0, 40, 32'h0000_0011, "R5 R10");
        op(0, 0, 0, 40, 0, "R5");
        op(0, 0, 1, 40, 0, "R5");
        op(0, 1, 0, 44, 0, "R5");
        set_grp(50, 0);
        op(1, 1, 0, 48, 32'h1020_3040, "R5 R7");
        op(0, 1, 1, 48, 0, "R5 R7");
        op(0, 1, 0, 48, 0, "R5 R6");

        // R4: security disabled, changed in the same cycle as the request
        op(0, 0, 0, 40, 0, "R4", 1, 1);
        op(1, 0, 0, 41, 32'h0000_0013, "R4");
        op(0, 0, 0, 41, 0, "R4");
        op(1, 0, 0, 42, 32'h0000_0022, "R5 R7", 1, 0);
        op(0, 0, 1, 42, 0, "R5");
        op(1, 0, 0, 51, 32'h0000_0022, "R7", 1, 0);
        op(0, 0, 1, 51, 0, "R7");

        // R8 R9: out-of-range handling
        op(1, 0, 1, 8, 32'h0000_0077, "R8 R10");
        op(0, 0, 1, 8, 0, "R8");
        op(0, 0, 1, 31, 0, "R8");
        op(1, 0, 1, 95, 32'h0000_0099, "R8 R10");
        op(0, 0, 1, 95, 0, "R8");
        op(1, 0, 1, 96, 32'h0000_0055, "R8");
        op(0, 0, 1, 100, 0, "R8");
        op(1, 1, 1, 28, 32'hAAAA_AAAA, "R9 R10");
        op(0, 1, 1, 28, 0, "R8 R9");
        op(0, 1, 1, 32, 0, "R9");
        op(1, 1, 1, 96, 32'hBBBB_BBBB, "R9");
        op(1, 1, 1, 92, 32'h0403_0201, "R9 R10");
        op(0, 1, 1, 92, 0, "R9");
        op(0, 1, 1, 96, 0, "R8");
        idle(1);

        // Random mix including same-cycle control changes
        for (int n = 0; n < 400; n++) begin
            int a;
            bit c;
            a = 24 + int'($urandom_range(0, 79));
            c = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) begin
                set_grp(32 + int'($urandom_range(0, NUM_IRQ - 33)), 1'($urandom_range(0, 1)));
            end
            op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               a, $urandom(), "RND", c, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 5) == 0) idle(1);
        end
        idle(2);

        done = 1;
        mon_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule